// File: doc/BRIEF.md
# Overlap Load Flag Sequencer

This block tracks how far an input block has been loaded into one transform element and drives a load-progress flag for the neighbouring elements. A start pulse latches a configuration (operating mode, overlap fraction, transform size, number of transforms in a group, input strobe divider). Samples then arrive on a valid/ready stream, and the flag drops once the fraction of the block set by the overlap has been taken in. When several short transforms are loaded back to back as one group, the flag falls twice: once in the first block and once more in the last block.

The flag is meant to start the load of the next element in a chain of elements with overlapping input blocks. The input side has a valid/ready handshake. `in_ready` is high only while a load is in progress. A beat transfers on any rising edge where both `in_valid` and `in_ready` are high. The source may raise or drop `in_valid` at any time, and while `in_ready` is low nothing is consumed. An optional divider counts only every second or fourth accepted beat as a sample, so that a stream clocked twice or four times faster can feed the element.

A configuration the element cannot honour raises an error flag, and no load begins.

Top module: `overlap_load_flag_seq`

## Requirements
- R1: The mode field `mode_sel` accepts 2'b01 (concurrent load/transform/dump) and 2'b10 (separate phases). A start with 2'b00 or 2'b11 sets `cfg_err` one edge later and leaves `load_active` low.
- R2: A start in concurrent mode (2'b01) with `size_log2` = 10 (1024 points) is rejected: `cfg_err` goes high and no load begins.
- R3: An accepted start drives `load_flag` and `load_active` high and `cfg_err` low on the next edge.
- R4: The block length is n = 2^`size_log2`. In the first block, `load_flag` falls on the edge that counts sample T. T is n/4 for `ovl_sel`=2 (75 % overlap), n/2 for `ovl_sel`=1 (50 %) and n for `ovl_sel`=0 (no overlap). `ovl_sel`=3 is a configuration error.
- R5: With `grp_num` = G > 1, `load_flag` rises again when the first sample of the second block is counted. It stays high through the middle blocks and falls again when sample T of the last block is counted.
- R6: `load_active` and `in_ready` drop on the edge that counts sample G·n. `load_flag` is low from then on until the next start.
- R7: `div_sel` = 0, 1 or 2 makes every 1st, 2nd or 4th accepted beat count as one sample. `div_sel` = 3 is a configuration error.
- R8: While a load is active, `start` and changes on the configuration inputs have no effect on the flag sequence, `load_active` or `cfg_err`.
- R9: `size_log2` outside 4..10 or `grp_num` = 0 is a configuration error.
- R10: After reset, `load_flag`, `load_active`, `cfg_err` and `in_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Operating mode, 01 concurrent, 10 separate phases |
| ovl_sel | input | 2 | Overlap: 0 none, 1 half, 2 three quarters |
| size_log2 | input | 4 | log2 of transform size (4..10) |
| grp_num | input | 4 | Number of blocks in a concurrent group (1..15) |
| div_sel | input | 2 | Input strobe divider: 0 by 1, 1 by 2, 2 by 4 |
| start | input | 1 | Begin a load procedure (taken only when idle) |
| in_valid | input | 1 | Sample beat offered |
| in_ready | output | 1 | Element can accept a beat |
| load_flag | output | 1 | Load-progress flag |
| load_active | output | 1 | Load procedure in progress |
| cfg_err | output | 1 | Last start carried an illegal configuration |

## Verification
A start is answered on the very next edge: `load_active`, `load_flag` and `cfg_err` are all registered. The bench therefore pulses start for one cycle and reads the outputs at the following falling edge. The flag and the active status change on the same edge that accepts the qualifying beat. So the bench counts accepted beats itself, works out the sample count from the divider, and after every cycle compares both outputs against the value expected for that count, half a clock after the edge. Error cases are read one cycle after their start pulse, together with `in_ready`, to confirm that no load began.

// File: rtl/olfs_pkg.sv
package olfs_pkg;
  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_CONC = 2'b01,
    MODE_SEP  = 2'b10,
    MODE_RSV  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    OVL_ZERO = 2'd0,
    OVL_HALF = 2'd1,
    OVL_QTR3 = 2'd2,
    OVL_RSV  = 2'd3
  } ovl_e;

  typedef enum logic [1:0] {
    DIV_1   = 2'd0,
    DIV_2   = 2'd1,
    DIV_4   = 2'd2,
    DIV_RSV = 2'd3
  } div_e;
endpackage

// File: rtl/olfs_cfg_check.sv
module olfs_cfg_check #(
  parameter int MIN_LOG2      = 4,
  parameter int MAX_LOG2      = 10,
  parameter int CONC_MAX_LOG2 = 9,
  parameter int GRP_W         = 4
) (
  input  logic [1:0]       mode_sel,
  input  logic [1:0]       ovl_sel,
  input  logic [3:0]       size_log2,
  input  logic [GRP_W-1:0] grp_num,
  input  logic [1:0]       div_sel,
  output logic             bad_cfg
);
  import olfs_pkg::*;

  logic mode_bad, size_bad, conc_bad, misc_bad;

  always_comb begin
    mode_bad = !(mode_sel == MODE_CONC || mode_sel == MODE_SEP);
    size_bad = (int'(size_log2) < MIN_LOG2) || (int'(size_log2) > MAX_LOG2);
    conc_bad = (mode_sel == MODE_CONC) && (int'(size_log2) > CONC_MAX_LOG2);
    misc_bad = (ovl_sel == OVL_RSV) || (div_sel == DIV_RSV) || (grp_num == '0);
    bad_cfg  = mode_bad | size_bad | conc_bad | misc_bad;
  end
endmodule

// File: rtl/olfs_strobe_div.sv
module olfs_strobe_div #(
  parameter int PRE_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       beat,
  input  logic [1:0] div_sel,
  output logic       tick
);
  import olfs_pkg::*;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_lim;

  always_comb begin
    unique case (div_sel)
      DIV_2:   pre_lim = PRE_W'(1);
      DIV_4:   pre_lim = PRE_W'(3);
      default: pre_lim = '0;
    endcase
    tick = beat && (pre_cnt == pre_lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pre_cnt <= '0;
    end else if (beat) begin
      pre_cnt <= tick ? '0 : pre_cnt + PRE_W'(1);
    end
  end
endmodule

// File: rtl/olfs_block_counter.sv
module olfs_block_counter #(
  parameter int CNT_W = 11,
  parameter int GRP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [3:0]       size_log2,
  input  logic [1:0]       ovl_sel,
  input  logic [GRP_W-1:0] grp_num,
  output logic             ev_fall,
  output logic             ev_rise,
  output logic             ev_done
);
  import olfs_pkg::*;

  logic [CNT_W-1:0] samp_cnt;
  logic [GRP_W-1:0] blk_cnt;
  logic [CNT_W-1:0] blk_len;
  logic [CNT_W-1:0] thresh;
  logic [CNT_W-1:0] samp_nxt;
  logic             is_first, is_last, blk_end;

  always_comb begin
    blk_len = CNT_W'(1) << size_log2;
    unique case (ovl_sel)
      OVL_QTR3: thresh = blk_len >> 2;
      OVL_HALF: thresh = blk_len >> 1;
      default:  thresh = blk_len;
    endcase
    samp_nxt = samp_cnt + CNT_W'(1);
    is_first = (blk_cnt == '0);
    is_last  = (blk_cnt == grp_num - GRP_W'(1));
    blk_end  = (samp_nxt == blk_len);
    ev_fall  = tick && (samp_nxt == thresh) && (is_first || is_last);
    ev_rise  = tick && (samp_cnt == '0) && (blk_cnt == GRP_W'(1));
    ev_done  = tick && blk_end && is_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      samp_cnt <= '0;
      blk_cnt  <= '0;
    end else if (tick) begin
      if (blk_end) begin
        samp_cnt <= '0;
        blk_cnt  <= blk_cnt + GRP_W'(1);
      end else begin
        samp_cnt <= samp_nxt;
      end
    end
  end
endmodule

// File: rtl/overlap_load_flag_seq.sv
module overlap_load_flag_seq #(
  parameter int MIN_LOG2      = 4,
  parameter int MAX_LOG2      = 10,
  parameter int CONC_MAX_LOG2 = MAX_LOG2 - 1,
  parameter int GRP_W         = 4,
  parameter int PRE_W         = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [1:0]       ovl_sel,
  input  logic [3:0]       size_log2,
  input  logic [GRP_W-1:0] grp_num,
  input  logic [1:0]       div_sel,
  input  logic             start,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             load_flag,
  output logic             load_active,
  output logic             cfg_err
);
  localparam int CNT_W = MAX_LOG2 + 1;

  logic             bad_cfg;
  logic             start_take;
  logic             beat, tick;
  logic             ev_fall, ev_rise, ev_done;
  logic [1:0]       ovl_q;
  logic [3:0]       size_q;
  logic [GRP_W-1:0] grp_q;
  logic [1:0]       div_q;

  olfs_cfg_check #(
    .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2),
    .CONC_MAX_LOG2(CONC_MAX_LOG2), .GRP_W(GRP_W)
  ) u_cfg (
    .mode_sel(mode_sel), .ovl_sel(ovl_sel), .size_log2(size_log2),
    .grp_num(grp_num), .div_sel(div_sel), .bad_cfg(bad_cfg)
  );

  assign start_take = start && !load_active;
  assign in_ready   = load_active;
  assign beat       = in_valid && load_active;

  olfs_strobe_div #(.PRE_W(PRE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(start_take),
    .beat(beat), .div_sel(div_q), .tick(tick)
  );

  olfs_block_counter #(.CNT_W(CNT_W), .GRP_W(GRP_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(start_take), .tick(tick),
    .size_log2(size_q), .ovl_sel(ovl_q), .grp_num(grp_q),
    .ev_fall(ev_fall), .ev_rise(ev_rise), .ev_done(ev_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_active <= 1'b0;
      load_flag   <= 1'b0;
      cfg_err     <= 1'b0;
      ovl_q       <= '0;
      size_q      <= '0;
      grp_q       <= '0;
      div_q       <= '0;
    end else if (start_take) begin
      if (bad_cfg) begin
        cfg_err   <= 1'b1;
        load_flag <= 1'b0;
      end else begin
        cfg_err     <= 1'b0;
        load_active <= 1'b1;
        load_flag   <= 1'b1;
        ovl_q       <= ovl_sel;
        size_q      <= size_log2;
        grp_q       <= grp_num;
        div_q       <= div_sel;
      end
    end else if (load_active) begin
      if (ev_done) load_active <= 1'b0;
      if (ev_fall)      load_flag <= 1'b0;
      else if (ev_rise) load_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/olfs_chk.sv
module olfs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic [3:0] size_log2,
  input logic       start,
  input logic       load_flag,
  input logic       load_active,
  input logic       cfg_err
);
  // R1
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !load_active);

  // R2
  conc_big_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !load_active && mode_sel == 2'b01 && size_log2 == 4'd10)
      |=> (cfg_err && !load_active));

  // R3
  flag_up_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_active) |-> (load_flag && !cfg_err));

  // R4
  flag_fall_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_flag) |-> $past(load_active));

  // R6
  done_flag_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_active) |-> !load_flag);

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_active && start) |=> !cfg_err);
endmodule

bind overlap_load_flag_seq olfs_chk u_olfs_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .size_log2(size_log2),
  .start(start), .load_flag(load_flag), .load_active(load_active),
  .cfg_err(cfg_err)
);

// File: tb/overlap_load_flag_seq_bench.sv
module overlap_load_flag_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b01;
  logic [1:0] ovl_sel = 2'd0;
  logic [3:0] size_log2 = 4'd4;
  logic [3:0] grp_num = 4'd1;
  logic [1:0] div_sel = 2'd0;
  logic       start = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready, load_flag, load_active, cfg_err;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  overlap_load_flag_seq u_overlap_load_flag_seq (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ovl_sel(ovl_sel),
    .size_log2(size_log2), .grp_num(grp_num), .div_sel(div_sel),
    .start(start), .in_valid(in_valid), .in_ready(in_ready),
    .load_flag(load_flag), .load_active(load_active), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // expected flag after s counted samples (R4, R5, R6)
  function automatic bit exp_flag(int s, int n, int t, int g);
    if (g == 1) return s < t;
    if (s < t) return 1'b1;
    if (s <= n) return 1'b0;
    if (s < (g - 1) * n + t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic run_load(input logic [1:0] md, input logic [1:0] ov,
                          input logic [3:0] sz, input logic [3:0] g,
                          input logic [1:0] dv);
    int n, t, d, beats, s;
    bit acc;
    n = 1 << sz;
    t = (ov == 2) ? n / 4 : (ov == 1) ? n / 2 : n;
    d = 1 << dv;
    @(negedge clk);
    mode_sel = md; ovl_sel = ov; size_log2 = sz; grp_num = g; div_sel = dv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R3: flag and status high, error cleared, one edge after start
    chk(load_flag && load_active && !cfg_err && in_ready, "R3",
        {load_flag, load_active, cfg_err}, 3'b110);
    beats = 0;
    forever begin
      s = beats / d;
      // R4 R5 flag sequence, R7 divider sets s
      chk(load_flag == exp_flag(s, n, t, int'(g)), "R4/R5/R7",
          load_flag, exp_flag(s, n, t, int'(g)));
      // R6 end of load
      chk(load_active == (s < int'(g) * n) && in_ready == load_active, "R6",
          load_active, s < int'(g) * n);
      if (s >= int'(g) * n) begin
        start = 1'b0;
        break;
      end
      in_valid = ($urandom % 4) != 0;
      // R8: stray start and config churn while loading
      start = ($urandom % 16) == 0;
      mode_sel = 2'($urandom); ovl_sel = 2'($urandom);
      size_log2 = 4'($urandom); grp_num = 4'($urandom); div_sel = 2'($urandom);
      acc = in_valid && in_ready;
      @(posedge clk);
      if (acc) beats++;
      @(negedge clk);
      if (cfg_err) chk(1'b0, "R8", cfg_err, 0);
      #0;
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk(!load_flag && !load_active, "R6", {load_flag, load_active}, 0);
  endtask

  task automatic run_bad(input logic [1:0] md, input logic [1:0] ov,
                         input logic [3:0] sz, input logic [3:0] g,
                         input logic [1:0] dv, input string req);
    @(negedge clk);
    mode_sel = md; ovl_sel = ov; size_log2 = sz; grp_num = g; div_sel = dv;
    start = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err && !load_active && !in_ready && !load_flag, req,
        {cfg_err, load_active, in_ready}, 3'b100);
    @(negedge clk);
    in_valid = 1'b0;
    chk(!load_active, req, load_active, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20517));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!load_flag && !load_active && !cfg_err && !in_ready, "R10",
        {load_flag, load_active, cfg_err, in_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!load_flag && !load_active && !cfg_err, "R10",
        {load_flag, load_active, cfg_err}, 0);

    // directed corners (R1 both modes, R4 fractions, R5 groups, R7 divider)
    run_load(2'b01, 2'd0, 4'd4, 4'd1, 2'd0);
    run_load(2'b01, 2'd1, 4'd4, 4'd1, 2'd0);
    run_load(2'b10, 2'd2, 4'd5, 4'd1, 2'd0);
    run_load(2'b01, 2'd2, 4'd4, 4'd4, 2'd0);
    run_load(2'b01, 2'd1, 4'd4, 4'd2, 2'd1);
    run_load(2'b10, 2'd0, 4'd4, 4'd3, 2'd2);
    run_load(2'b10, 2'd0, 4'd10, 4'd1, 2'd0);

    // configuration errors (R1, R2, R4, R7, R9), each followed by recovery
    run_bad(2'b00, 2'd0, 4'd4, 4'd1, 2'd0, "R1");
    run_bad(2'b11, 2'd0, 4'd4, 4'd1, 2'd0, "R1");
    run_bad(2'b01, 2'd0, 4'd10, 4'd1, 2'd0, "R2");
    run_bad(2'b10, 2'd3, 4'd4, 4'd1, 2'd0, "R4");
    run_bad(2'b10, 2'd0, 4'd4, 4'd1, 2'd3, "R7");
    run_bad(2'b10, 2'd0, 4'd3, 4'd1, 2'd0, "R9");
    run_bad(2'b10, 2'd0, 4'd11, 4'd1, 2'd0, "R9");
    run_bad(2'b10, 2'd0, 4'd4, 4'd0, 2'd0, "R9");
    run_load(2'b01, 2'd2, 4'd4, 4'd2, 2'd0);

    // constrained random loads
    for (int i = 0; i < 14; i++) begin
      run_load(($urandom % 2) ? 2'b01 : 2'b10, 2'($urandom % 3),
               4'(4 + $urandom % 4), 4'(1 + $urandom % 3), 2'($urandom % 3));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule